// File: doc/BRIEF.md
# BERT Test Pattern Generator

This block is a serial bit source for bit-error-rate measurement. Each cycle with the bit enable high, it emits one bit of a pattern chosen by a 3-bit select: one of three maximal-length pseudorandom sequences, a quasi-random variant with long zero runs suppressed, a programmable repetitive word, or an alternating pair of 16-bit words. A transmit-invert input complements the outgoing stream. Two select codes are reserved. For these the block raises an illegal flag and holds the line at 0.

Each pattern has its own generator. A small mode FSM in the top module picks a generator, registers the emitted bit and decides when a pattern must start again. The mode FSM has five states. `M_IDLE` is entered at reset, before any bit has been sent. `M_PRBS`, `M_REP` and `M_ALT` are the three pattern families. `M_ILLEGAL` covers the reserved codes. On every enabled bit the FSM moves to the state that matches the present select. A restart happens when that bit is taken from `M_IDLE`, or when the select or the length code differs from the values captured on the previous enabled bit. On a restart the chosen generator emits the first bit of its pattern, starting from its initial state.

The alternating-word generator has its own two-state machine. `WORD_A` sends word A a programmed number of times plus one. It then moves to `WORD_B`, which sends word B once and returns to `WORD_A`.

Top module: `bert_patgen`

## Requirements
- R1: Select 000, 001 and 010 give the sequences of x^7+x^6+1, x^11+x^9+1 and x^15+x^14+1. Each register starts at all ones, emits its oldest (top) bit, then shifts left and takes in the XOR of the two tap bits.
- R2: Select 011 gives the x^20+x^17+1 sequence, built the same way. An emitted bit is forced to 1 when the 14 bits that follow it in the register (bits 18 down to 5) are all 0. The output therefore never holds more than 14 consecutive zeros.
- R3: Select 100 sends the 32-bit repetitive word LSB first. It wraps to bit 0 after len_code+17 bits, so code 0000 gives 17 bits and 1111 gives 32 bits.
- R4: A pattern shorter than 17 bits is sent by loading a whole multiple of it, no longer than 32 bits, into the word and giving that multiple as the length. Example: a 6-bit pattern with code 0001 (18 bits).
- R5: Select 101 sends word A LSB first, alt_reps+1 times in a row, then word B once. Both words are 16 bits. The cycle then repeats.
- R6: Select 110 and 111 set sel_illegal to 1 and force bit_out to 0, whatever tx_invert is. For the legal codes sel_illegal is 0.
- R7: While tx_invert is 1, bit_out is the complement of the pattern bit. The change is immediate, with no enable needed.
- R8: bit_out changes only on clock edges where bit_en is 1. Otherwise it holds and the pattern does not advance.
- R9: The first enabled bit after reset restarts the selected pattern from its initial state. So does any enabled bit whose select or length code differs from the values on the previous enabled bit.
- R10: After reset, before any enabled bit, bit_out is 0 (with tx_invert 0). The emitted bit appears at bit_out just after the enabled clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | Emit one bit at this edge |
| pat_sel | input | 3 | Pattern select code |
| len_code | input | 4 | Repetitive length code, length = code+17 |
| rep_word | input | 32 | Repetitive word, sent LSB first |
| alt_word_a | input | 16 | Alternating word A |
| alt_word_b | input | 16 | Alternating word B |
| alt_reps | input | 4 | Word A is sent alt_reps+1 times per cycle |
| tx_invert | input | 1 | Complement the outgoing bits |
| bit_out | output | 1 | Serial pattern bit |
| sel_illegal | output | 1 | Select is a reserved code |

## Verification
Some properties are checked by assertions on every cycle:
- the pseudorandom registers never reach the all-zero lock-up state;
- the quasi-random output never holds more than 14 zeros in a row;
- the repetitive bit index never passes the programmed length;
- the FSM lands in the state that matches the select;
- bit_out holds between enabled edges;
- the reserved codes store a 0.

Other behaviour needs the bench scenarios, which compare every emitted bit against a model of the polynomials and words. These scenarios cover:
- the exact bit order of each sequence;
- restarts when the select or length code changes;
- the 6-bit sub-length pattern;
- the A/A/B word cadence;
- the immediate effect of invert.

// File: rtl/bert_pkg.sv
`timescale 1ns/1ps
package bert_pkg;

    localparam logic [2:0] SEL_PRBS7  = 3'd0;
    localparam logic [2:0] SEL_PRBS11 = 3'd1;
    localparam logic [2:0] SEL_PRBS15 = 3'd2;
    localparam logic [2:0] SEL_QRSS   = 3'd3;
    localparam logic [2:0] SEL_REP    = 3'd4;
    localparam logic [2:0] SEL_ALT    = 3'd5;

    localparam int NUM_LFSR = 4;
    localparam int QRSS_RUN = 14;

    typedef enum logic [2:0] {
        M_IDLE,
        M_PRBS,
        M_REP,
        M_ALT,
        M_ILLEGAL
    } mode_e;

    typedef enum logic {
        WORD_A,
        WORD_B
    } alt_e;

    function automatic int lfsr_width(input int idx);
        case (idx)
            0: return 7;
            1: return 11;
            2: return 15;
            default: return 20;
        endcase
    endfunction

    function automatic int lfsr_tap(input int idx);
        case (idx)
            0: return 6;
            1: return 9;
            2: return 14;
            default: return 17;
        endcase
    endfunction

    function automatic int lfsr_run(input int idx);
        return (idx == 3) ? QRSS_RUN : 0;
    endfunction

endpackage

// File: rtl/bert_lfsr.sv
`timescale 1ns/1ps
module bert_lfsr #(
    parameter int WIDTH = 7,
    parameter int TAP   = 6,
    parameter int RUN   = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic restart,
    output logic bit_o
);

    logic [WIDTH-1:0] state;
    logic [WIDTH-1:0] cur;
    logic             fb;
    logic             force_one;

    assign cur = restart ? {WIDTH{1'b1}} : state;
    assign fb  = cur[WIDTH-1] ^ cur[TAP-1];

    generate
        if (RUN > 0) begin : g_suppress
            assign force_one = (cur[WIDTH-2 -: RUN] == '0);

            logic [$clog2(RUN+2)-1:0] zrun;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    zrun <= '0;
                end else if (step) begin
                    if (bit_o)        zrun <= '0;
                    else if (restart) zrun <= 1;
                    else              zrun <= zrun + 1'b1;
                end
            end

            a_r2_zero_run: assert property (@(posedge clk) disable iff (!rst_n)
                zrun <= RUN);
        end else begin : g_plain
            assign force_one = 1'b0;
        end
    endgenerate

    assign bit_o = cur[WIDTH-1] | force_one;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= {WIDTH{1'b1}};
        end else if (step) begin
            state <= {cur[WIDTH-2:0], fb};
        end
    end

    a_r1_state_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);

endmodule

// File: rtl/bert_rep_gen.sv
`timescale 1ns/1ps
module bert_rep_gen #(
    parameter int REP_MAX  = 32,
    parameter int LEN_BASE = 17
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   step,
    input  logic                                   restart,
    input  logic [$clog2(REP_MAX-LEN_BASE+1)-1:0]  len_code,
    input  logic [REP_MAX-1:0]                     word,
    output logic                                   bit_o
);

    localparam int IDX_W = $clog2(REP_MAX);

    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] cur_idx;
    logic [IDX_W-1:0] last_idx;

    assign last_idx = IDX_W'(len_code) + IDX_W'(LEN_BASE - 1);
    assign cur_idx  = restart ? '0 : idx;
    assign bit_o    = word[cur_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (step) begin
            idx <= (cur_idx == last_idx) ? '0 : cur_idx + 1'b1;
        end
    end

    a_r3_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (idx <= $past(last_idx)));

endmodule

// File: rtl/bert_alt_gen.sv
`timescale 1ns/1ps
module bert_alt_gen
    import bert_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int REPS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              restart,
    input  logic [WORD_W-1:0] word_a,
    input  logic [WORD_W-1:0] word_b,
    input  logic [REPS_W-1:0] reps,
    output logic              bit_o
);

    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

    alt_e              ph, cur_ph, ph_d;
    logic [BIT_W-1:0]  bidx, cur_bit, bidx_d;
    logic [REPS_W-1:0] cnt, cur_cnt, cnt_d;

    assign cur_ph  = restart ? WORD_A : ph;
    assign cur_bit = restart ? '0 : bidx;
    assign cur_cnt = restart ? '0 : cnt;

    always_comb begin
        ph_d   = cur_ph;
        bidx_d = cur_bit + 1'b1;
        cnt_d  = cur_cnt;
        if (cur_bit == LAST_BIT) begin
            bidx_d = '0;
            unique case (cur_ph)
                WORD_A: begin
                    if (cur_cnt == reps) ph_d = WORD_B;
                    else                 cnt_d = cur_cnt + 1'b1;
                end
                WORD_B: begin
                    ph_d  = WORD_A;
                    cnt_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph   <= WORD_A;
            bidx <= '0;
            cnt  <= '0;
        end else if (step) begin
            ph   <= ph_d;
            bidx <= bidx_d;
            cnt  <= cnt_d;
        end
    end

    always_comb begin
        unique case (cur_ph)
            WORD_A: bit_o = word_a[cur_bit];
            WORD_B: bit_o = word_b[cur_bit];
        endcase
    end

    a_r5_b_returns_to_a: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cur_ph == WORD_B && cur_bit == LAST_BIT) |=> (ph == WORD_A && cnt == '0));

endmodule

// File: rtl/bert_patgen.sv
`timescale 1ns/1ps
module bert_patgen
    import bert_pkg::*;
#(
    parameter int REP_MAX  = 32,
    parameter int LEN_BASE = 17,
    parameter int ALT_W    = 16,
    parameter int REPS_W   = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  bit_en,
    input  logic [2:0]                            pat_sel,
    input  logic [$clog2(REP_MAX-LEN_BASE+1)-1:0] len_code,
    input  logic [REP_MAX-1:0]                    rep_word,
    input  logic [ALT_W-1:0]                      alt_word_a,
    input  logic [ALT_W-1:0]                      alt_word_b,
    input  logic [REPS_W-1:0]                     alt_reps,
    input  logic                                  tx_invert,
    output logic                                  bit_out,
    output logic                                  sel_illegal
);

    localparam int LEN_W = $clog2(REP_MAX - LEN_BASE + 1);
    localparam int CFG_W = 3 + LEN_W;

    mode_e              state, state_d;
    logic [CFG_W-1:0]   cfg_q;
    logic [CFG_W-1:0]   cfg_now;
    logic               restart;
    logic [NUM_LFSR-1:0] prbs_bit;
    logic               rep_bit;
    logic               alt_bit;
    logic               pick_bit;
    logic               bit_q;

    assign cfg_now     = {pat_sel, len_code};
    assign restart     = bit_en && ((state == M_IDLE) || (cfg_now != cfg_q));
    assign sel_illegal = pat_sel[2] & pat_sel[1];

    // Pseudorandom generators, one per select code 000..011
    generate
        for (genvar g = 0; g < NUM_LFSR; g++) begin : g_lfsr
            bert_lfsr #(
                .WIDTH(lfsr_width(g)),
                .TAP  (lfsr_tap(g)),
                .RUN  (lfsr_run(g))
            ) u_lfsr (
                .clk    (clk),
                .rst_n  (rst_n),
                .step   (bit_en && (pat_sel == 3'(g))),
                .restart(restart),
                .bit_o  (prbs_bit[g])
            );
        end
    endgenerate

    bert_rep_gen #(
        .REP_MAX (REP_MAX),
        .LEN_BASE(LEN_BASE)
    ) u_rep (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (bit_en && (pat_sel == SEL_REP)),
        .restart (restart),
        .len_code(len_code),
        .word    (rep_word),
        .bit_o   (rep_bit)
    );

    bert_alt_gen #(
        .WORD_W(ALT_W),
        .REPS_W(REPS_W)
    ) u_alt (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (bit_en && (pat_sel == SEL_ALT)),
        .restart(restart),
        .word_a (alt_word_a),
        .word_b (alt_word_b),
        .reps   (alt_reps),
        .bit_o  (alt_bit)
    );

    // Mode transitions: every enabled bit moves to the mode of the select
    always_comb begin
        state_d = state;
        if (bit_en) begin
            unique case (pat_sel)
                SEL_PRBS7, SEL_PRBS11, SEL_PRBS15, SEL_QRSS: state_d = M_PRBS;
                SEL_REP:                                     state_d = M_REP;
                SEL_ALT:                                     state_d = M_ALT;
                default:                                     state_d = M_ILLEGAL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= M_IDLE;
            cfg_q <= '0;
        end else begin
            state <= state_d;
            if (bit_en) cfg_q <= cfg_now;
        end
    end

    // Output: pick the generator bit for the mode being entered
    always_comb begin
        unique case (state_d)
            M_PRBS:  pick_bit = prbs_bit[pat_sel[1:0]];
            M_REP:   pick_bit = rep_bit;
            M_ALT:   pick_bit = alt_bit;
            default: pick_bit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bit_q <= 1'b0;
        else if (bit_en) bit_q <= pick_bit;
    end

    assign bit_out = sel_illegal ? 1'b0 : (bit_q ^ tx_invert);

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(bit_q));

    a_r6_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == M_ILLEGAL) |-> !bit_q);

    a_r9_rep_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && pat_sel == SEL_REP) |=> (state == M_REP));

    a_r9_prbs_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && pat_sel[2] == 1'b0) |=> (state == M_PRBS));

endmodule

// File: tb/bert_patgen_test.sv
`timescale 1ns/1ps
module bert_patgen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic [2:0]  pat_sel = 3'd0;
    logic [3:0]  len_code = 4'd0;
    logic [31:0] rep_word = '0;
    logic [15:0] alt_word_a = '0;
    logic [15:0] alt_word_b = '0;
    logic [3:0]  alt_reps = '0;
    logic        tx_invert = 1'b0;
    logic        bit_out;
    logic        sel_illegal;

    int n_checks = 0;
    int n_fail   = 0;

    bit    exp_q[$];
    string tag_q[$];

    // model state
    bit          m_started = 0;
    logic [6:0]  m_cfg;
    logic [19:0] m_s;
    int          m_idx, m_bit, m_cnt;
    bit          m_ph;
    int          zrun = 0, zmax = 0;

    always #2 clk = ~clk;   // 250 MHz

    bert_patgen uut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .pat_sel(pat_sel),
        .len_code(len_code), .rep_word(rep_word), .alt_word_a(alt_word_a),
        .alt_word_b(alt_word_b), .alt_reps(alt_reps), .tx_invert(tx_invert),
        .bit_out(bit_out), .sel_illegal(sel_illegal)
    );

    task automatic check(input bit act, input bit exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // reference model of one emitted bit
    task automatic model_step(output bit e);
        bit restart, b, fb;
        int w, t;
        logic [19:0] mask;
        restart = !m_started || ({pat_sel, len_code} != m_cfg);
        m_started = 1;
        m_cfg = {pat_sel, len_code};
        b = 0;
        if (pat_sel <= 3) begin
            w = (pat_sel == 0) ? 7 : (pat_sel == 1) ? 11 : (pat_sel == 2) ? 15 : 20;
            t = (pat_sel == 0) ? 6 : (pat_sel == 1) ? 9 : (pat_sel == 2) ? 14 : 17;
            mask = 20'((64'd1 << w) - 1);
            if (restart) m_s = mask;
            b = m_s[w-1];
            if (pat_sel == 3 && m_s[18:5] == 14'd0) b = 1;
            fb = m_s[w-1] ^ m_s[t-1];
            m_s = ((m_s << 1) | 20'(fb)) & mask;
        end else if (pat_sel == 4) begin
            if (restart) m_idx = 0;
            b = rep_word[m_idx];
            m_idx = (m_idx == int'(len_code) + 16) ? 0 : m_idx + 1;
        end else if (pat_sel == 5) begin
            if (restart) begin m_ph = 0; m_bit = 0; m_cnt = 0; end
            b = m_ph ? alt_word_b[m_bit] : alt_word_a[m_bit];
            if (m_bit == 15) begin
                m_bit = 0;
                if (m_ph) begin m_ph = 0; m_cnt = 0; end
                else if (m_cnt == int'(alt_reps)) m_ph = 1;
                else m_cnt++;
            end else m_bit++;
        end
        e = (pat_sel >= 6) ? 1'b0 : (b ^ tx_invert);
    endtask

    // driver: one enabled bit per cycle, expected values pushed to the scoreboard
    task automatic send(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            bit e;
            @(negedge clk);
            model_step(e);
            exp_q.push_back(e);
            tag_q.push_back(tag);
            bit_en = 1'b1;
        end
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    // monitor: compare after each enabled edge
    logic mon_en;
    always @(posedge clk) begin
        mon_en = bit_en;
        #1;
        if (mon_en && exp_q.size() > 0) begin
            bit e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(bit_out, e, t);
            if (t == "R2") begin
                zrun = bit_out ? 0 : zrun + 1;
                if (zrun > zmax) zmax = zrun;
            end
        end
    end

    initial begin
        #(4 * 190000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        bit v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(bit_out, 1'b0, "R10 reset bit_out");
        check(sel_illegal, 1'b0, "R10/R6 flag low for legal code");

        // R1: three pseudorandom sequences (select change restarts, R9)
        pat_sel = 3'd0; send(140, "R1 prbs7");
        pat_sel = 3'd1; send(200, "R1 prbs11");
        pat_sel = 3'd2; send(200, "R1 prbs15");

        // R9: restart when returning to a code mid-sequence
        pat_sel = 3'd0; send(10, "R9 prbs7 part");
        pat_sel = 3'd1; send(5, "R9 prbs11 part");
        pat_sel = 3'd0; send(20, "R9 prbs7 restarted");

        // R8: hold while disabled, then continue without restart
        @(negedge clk);
        v = bit_out;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(bit_out, v, "R8 hold");
        end
        // R7: invert acts at once
        tx_invert = 1'b1;
        #1 check(bit_out, ~v, "R7 immediate invert");
        @(negedge clk);
        tx_invert = 1'b0;
        #1 check(bit_out, v, "R7 invert released");
        send(15, "R8 continue");

        // R2: quasi-random with zero-run limit
        pat_sel = 3'd3; send(40000, "R2");
        n_checks++;
        if (zmax > 14) begin
            n_fail++;
            $display("FAIL R2 zero run: actual %0d expected <=14", zmax);
        end

        // R3: repetitive word, 32 and 17 bits (length change restarts, R9)
        rep_word = 32'hDEADBEEF;
        pat_sel = 3'd4; len_code = 4'd15; send(70, "R3 len32");
        len_code = 4'd0; send(40, "R3 len17");

        // R7: invert across a run
        tx_invert = 1'b1; send(40, "R7 inverted rep");
        tx_invert = 1'b0;

        // R4: 6-bit pattern 101100 repeated three times, length code 0001
        rep_word = {14'd0, 6'b101100, 6'b101100, 6'b101100};
        len_code = 4'd1;
        send(36, "R4 six-bit");

        // R5: alternating A,A,B
        alt_word_a = 16'h1234; alt_word_b = 16'hF00F; alt_reps = 4'd1;
        pat_sel = 3'd5; send(96, "R5 alt");

        // R6: reserved codes
        tx_invert = 1'b1;
        pat_sel = 3'd6;
        @(negedge clk);
        check(sel_illegal, 1'b1, "R6 flag 110");
        check(bit_out, 1'b0, "R6 zero 110");
        send(4, "R6 code 110");
        pat_sel = 3'd7;
        @(negedge clk);
        check(sel_illegal, 1'b1, "R6 flag 111");
        send(4, "R6 code 111");
        tx_invert = 1'b0;
        pat_sel = 3'd0;
        @(negedge clk);
        check(sel_illegal, 1'b0, "R6 flag cleared");
        send(20, "R9 prbs7 after illegal");

        repeat (3) @(negedge clk);
        summary();
    end

endmodule